// File: doc/BRIEF.md
# Battery-Backed Power Mode Controller

This block tracks the operating mode of a metering-style chip as mains power comes and goes. One mode is the normal powered mode. The other three are battery modes: brownout, display-only and sleep. Brownout is the hub of battery operation. Every loss of supply lands there, and every wake event returns there. From brownout, processor request bits choose between display-only and sleep.

A flag register records the events the processor needs to see. These are leaving normal mode, entering normal mode, a wake-timer timeout and a pushbutton press. Each flag stays set until the processor writes a 1 to its bit. A weak battery forces the controller into sleep. It then stays in sleep, even if the battery recovers, until system power returns or a reset arrives while the battery is good. The pushbutton and both supply-status inputs pass through synchronisers, `SYNC_STAGES` flip-flops deep, before any logic uses them.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is held, `mode` reads brownout (2'b01) and `irq_flags` reads 0. After reset, the controller enters normal mode (2'b00) once supply is good and `pll_lock` is high, and it sets bit 6 of `irq_flags` on that entry.
- R2: In normal mode, `sys_pwr` going low or `vsense_low` going high moves the controller to brownout and sets bit 7 of `irq_flags`.
- R3: In brownout on battery with the battery good, `req_sleep` moves the controller to sleep (2'b11). Otherwise `req_disp` moves it to display-only (2'b10). When both are set, sleep wins.
- R4: In display-only or sleep without a low-battery latch, a high `wake_tmo` or a rising edge of the synchronised `pbtn` returns the controller to brownout.
- R5: A high `wake_tmo` sets bit 5 of `irq_flags`. A rising edge of the synchronised `pbtn` sets bit 4. Holding `pbtn` high sets bit 4 only once.
- R6: On battery, a low `bat_ok` moves the controller to sleep from any battery mode.
- R7: After a low-battery entry into sleep, the controller stays in sleep while on battery, whatever the state of `bat_ok`, wake events or requests.
- R8: The return of good supply releases the low-battery latch, and so does a reset. After a reset with `bat_ok` high on battery, the controller stays in brownout.
- R9: When good supply returns in a battery mode, the controller moves to brownout while `pll_lock` is low. It moves to normal mode in the cycle after `pll_lock` is high.
- R10: A write with `flag_clr_we` high clears each `irq_flags` bit whose `flag_clr` bit is 1. An event in the same cycle as the clear keeps its flag set. Bits 3..0 always read 0.
- R11: A change on `sys_pwr` or `vsense_low` changes `mode` on the (`SYNC_STAGES`+1)-th rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sys_pwr | input | 1 | System supply present (asynchronous) |
| vsense_low | input | 1 | Sensed supply at or below the bias threshold (asynchronous) |
| pll_lock | input | 1 | PLL reports stable |
| pbtn | input | 1 | Pushbutton, high when pressed (asynchronous) |
| wake_tmo | input | 1 | Wake-timer timeout pulse |
| bat_ok | input | 1 | Battery voltage adequate |
| req_disp | input | 1 | Processor request for display-only mode |
| req_sleep | input | 1 | Processor request for sleep mode |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 8 | Mask of flags to clear |
| mode | output | 2 | Current mode: 00 normal, 01 brownout, 10 display-only, 11 sleep |
| irq_flags | output | 8 | Event flags: 7 PLL fall, 6 PLL rise, 5 wake timeout, 4 pushbutton |

## Verification
The bench builds the controller with `SYNC_STAGES` = 2. At that depth the synchroniser delay is short and exact, so the bench can check cycle by cycle that a supply change does not act before the third edge and does act on it. It sweeps every combination of the two request bits in brownout and checks that sleep takes priority. It also checks the low-battery latch against each possible release, and tests a flag clear that arrives in the same cycle as a new event.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_pwr,
  input  logic       vsense_low,
  input  logic       pll_lock,
  input  logic       pbtn,
  input  logic       wake_tmo,
  input  logic       bat_ok,
  input  logic       req_disp,
  input  logic       req_sleep,
  input  logic       flag_clr_we,
  input  logic [7:0] flag_clr,
  output logic [1:0] mode,
  output logic [7:0] irq_flags
);

  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_BRN  = 2'b01;
  localparam logic [1:0] M_DISP = 2'b10;
  localparam logic [1:0] M_SLP  = 2'b11;
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] pw_sh, vl_sh, pb_sh;
  logic         pb_prev, lock_q;
  logic [1:0]   mode_d;
  logic         lock_d;
  logic [7:0]   flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_sh   <= '0;
      vl_sh   <= '1;
      pb_sh   <= '0;
      pb_prev <= 1'b0;
    end else begin
      pw_sh   <= {pw_sh[TOP-1:0], sys_pwr};
      vl_sh   <= {vl_sh[TOP-1:0], vsense_low};
      pb_sh   <= {pb_sh[TOP-1:0], pbtn};
      pb_prev <= pb_sh[TOP];
    end
  end

  wire pwr_ok  = pw_sh[TOP] & ~vl_sh[TOP];
  wire pb_rise = pb_sh[TOP] & ~pb_prev;
  wire wake_ev = pb_rise | wake_tmo;

  always_comb begin
    mode_d = mode;
    lock_d = lock_q;
    if (mode == M_NORM) begin
      if (!pwr_ok) mode_d = M_BRN;
    end else if (pwr_ok) begin
      lock_d = 1'b0;
      mode_d = pll_lock ? M_NORM : M_BRN;
    end else if (!bat_ok || lock_q) begin
      lock_d = 1'b1;
      mode_d = M_SLP;
    end else if (mode == M_BRN) begin
      if (req_sleep)     mode_d = M_SLP;
      else if (req_disp) mode_d = M_DISP;
    end else if (wake_ev) begin
      mode_d = M_BRN;
    end
  end

  assign flag_set = {(mode == M_NORM) && (mode_d != M_NORM),
                     (mode != M_NORM) && (mode_d == M_NORM),
                     wake_tmo, pb_rise, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_BRN;
      lock_q    <= 1'b0;
      irq_flags <= '0;
    end else begin
      mode      <= mode_d;
      lock_q    <= lock_d;
      irq_flags <= (irq_flags & ~(flag_clr_we ? flag_clr : 8'h00)) | flag_set;
    end
  end

  // R2
  pll_fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && !pwr_ok) |=> (mode == M_BRN && irq_flags[7]));

  // R9
  no_unlocked_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM && !pll_lock) |=> (mode != M_NORM));

  // R1
  pll_rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM && pwr_ok && pll_lock) |=> (mode == M_NORM && irq_flags[6]));

  // R7
  sleep_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !pwr_ok) |=> (mode == M_SLP));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[5] && !(flag_clr_we && flag_clr[5])) |=> irq_flags[5]);

  // R10
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags[3:0] == 4'b0000);

endmodule

// File: tb/pwr_mode_ctl_tb_top.sv
module pwr_mode_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_pwr = 1'b1, vsense_low = 1'b0, pll_lock = 1'b0, pbtn = 1'b0;
  logic wake_tmo = 1'b0, bat_ok = 1'b1, req_disp = 1'b0, req_sleep = 1'b0;
  logic flag_clr_we = 1'b0;
  logic [7:0] flag_clr = 8'h00;
  logic [1:0] mode;
  logic [7:0] irq_flags;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] NORM = 2'b00, BRN = 2'b01, DISP = 2'b10, SLP = 2'b11;

  always #4 clk = ~clk;

  pwr_mode_ctl #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_pwr(sys_pwr), .vsense_low(vsense_low),
    .pll_lock(pll_lock), .pbtn(pbtn), .wake_tmo(wake_tmo), .bat_ok(bat_ok),
    .req_disp(req_disp), .req_sleep(req_sleep), .flag_clr_we(flag_clr_we),
    .flag_clr(flag_clr), .mode(mode), .irq_flags(irq_flags));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_all();
    flag_clr_we = 1'b1; flag_clr = 8'hFF;
    tick(1);
    flag_clr_we = 1'b0; flag_clr = 8'h00;
  endtask

  task automatic press();
    pbtn = 1'b1; tick(5);
  endtask

  initial begin
    tick(3);
    chk("R1 reset mode", {6'b0, mode}, {6'b0, BRN});
    chk("R1 reset flags", irq_flags, 8'h00);
    rst_n = 1'b1;
    tick(5);
    chk("R9 no lock stays brownout", {6'b0, mode}, {6'b0, BRN});
    pll_lock = 1'b1; tick(2);
    chk("R1 enter normal", {6'b0, mode}, {6'b0, NORM});
    chk("R1 rise flag", irq_flags, 8'h40);
    flag_clr_we = 1'b1; flag_clr = 8'h40; tick(1);
    flag_clr_we = 1'b0; flag_clr = 8'h00;
    chk("R10 clear on write", irq_flags, 8'h00);

    sys_pwr = 1'b0; tick(2);
    chk("R11 no early change", {6'b0, mode}, {6'b0, NORM});
    tick(1);
    chk("R11 change on third edge", {6'b0, mode}, {6'b0, BRN});
    chk("R2 fall flag", irq_flags, 8'h80);
    clear_all();

    req_disp = 1'b1; tick(2); req_disp = 1'b0;
    chk("R3 display request", {6'b0, mode}, {6'b0, DISP});
    wake_tmo = 1'b1; tick(1); wake_tmo = 1'b0; tick(1);
    chk("R4 timeout wakes", {6'b0, mode}, {6'b0, BRN});
    chk("R5 timeout flag", irq_flags, 8'h20);
    clear_all();

    for (int i = 1; i < 4; i++) begin
      req_disp = i[0]; req_sleep = i[1]; tick(2);
      req_disp = 1'b0; req_sleep = 1'b0;
      chk("R3 request sweep", {6'b0, mode}, {6'b0, (i[1] ? SLP : DISP)});
      press();
      chk("R4 button wakes", {6'b0, mode}, {6'b0, BRN});
      chk("R5 button flag", irq_flags, 8'h10);
      clear_all(); tick(3);
      chk("R5 held button no reflag", irq_flags, 8'h00);
      pbtn = 1'b0; tick(3);
    end

    wake_tmo = 1'b1; flag_clr_we = 1'b1; flag_clr = 8'h20; tick(1);
    wake_tmo = 1'b0; flag_clr_we = 1'b0; flag_clr = 8'h00;
    chk("R10 set wins over clear", irq_flags, 8'h20);
    clear_all();

    sys_pwr = 1'b1; tick(5);
    chk("R9 power return normal", {6'b0, mode}, {6'b0, NORM});
    clear_all();
    vsense_low = 1'b1; tick(4);
    chk("R2 sense low brownout", {6'b0, mode}, {6'b0, BRN});
    chk("R2 sense low flag", irq_flags, 8'h80);
    clear_all();

    bat_ok = 1'b0; tick(2);
    chk("R6 low battery sleep", {6'b0, mode}, {6'b0, SLP});
    bat_ok = 1'b1; tick(2);
    chk("R7 stays after recovery", {6'b0, mode}, {6'b0, SLP});
    wake_tmo = 1'b1; tick(1); wake_tmo = 1'b0;
    press(); pbtn = 1'b0;
    req_disp = 1'b1; tick(3); req_disp = 1'b0;
    chk("R7 wake ignored when latched", {6'b0, mode}, {6'b0, SLP});
    clear_all();

    vsense_low = 1'b0; tick(5);
    chk("R8 power return releases", {6'b0, mode}, {6'b0, NORM});
    vsense_low = 1'b1; tick(5);
    chk("R8 latch released", {6'b0, mode}, {6'b0, BRN});

    bat_ok = 1'b0; tick(2);
    chk("R6 sleep again", {6'b0, mode}, {6'b0, SLP});
    bat_ok = 1'b1; rst_n = 1'b0; tick(2);
    chk("R1 reset flags again", irq_flags, 8'h00);
    rst_n = 1'b1; tick(5);
    chk("R8 reset releases", {6'b0, mode}, {6'b0, BRN});

    pll_lock = 1'b0; req_sleep = 1'b1; tick(2); req_sleep = 1'b0;
    chk("R3 sleep before return", {6'b0, mode}, {6'b0, SLP});
    vsense_low = 1'b0; tick(5);
    chk("R9 unlocked return brownout", {6'b0, mode}, {6'b0, BRN});
    pll_lock = 1'b1; tick(2);
    chk("R9 lock gives normal", {6'b0, mode}, {6'b0, NORM});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule